// File: doc/BRIEF.md
# Isochronous Cycle Start Generator

This block sits in the 50 MHz link clock domain of a serial-bus link controller. It marks the start of every isochronous cycle. When the node acts as cycle master, the block derives the nominal 125 µs cycle from one of two sources. The first is an internal period counter. The second is an optional external 8 kHz cycle clock, which passes through a synchroniser and an edge detector.

At each cycle start the block emits exactly one single-clock pulse (20 ns at 50 MHz). It also raises a level request asking the transmitter to send a cycle start packet. The request is held until the transmitter acknowledges it.

In external mode the block watches for late edges. If no rising edge of the external clock arrives within one and a half nominal periods, it raises a missed-cycle flag.

The control is a four-state machine:

- `ST_IDLE`: cycle master disabled.
- `ST_INT`: running from the internal counter.
- `ST_EXT_WAIT`: external source selected, waiting for an edge.
- `ST_EXT_MISS`: external source selected, and the edge is overdue.

The transitions are:

- Any state moves to `ST_IDLE` whenever the enable is low.
- `ST_IDLE` moves to `ST_INT` or to `ST_EXT_WAIT`, according to the source select.
- `ST_INT` moves to `ST_EXT_WAIT` when the external source is selected.
- Either external state moves to `ST_INT` when the internal source is selected.
- `ST_EXT_WAIT` moves to `ST_EXT_MISS` on timeout.
- `ST_EXT_MISS` moves back to `ST_EXT_WAIT` on an external rising edge.

Every change of state restarts the period counter. An external rising edge also restarts it.

Top module: `cycle_tick_gen`

## Requirements
- R1: While `rst` is sampled high at a clock edge, and right after it, `cycle_pulse`, `cs_req` and `cycle_missed` are all 0.
- R2: `cycle_pulse` is never high for two consecutive clock cycles.
- R3: In internal mode (`master_en`=1, `use_ext`=0), `cycle_pulse` goes high after the (PERIOD_CLKS+1)-th rising edge, counted from the first edge that samples the mode. After that it repeats every PERIOD_CLKS clocks. The default PERIOD_CLKS is 6250.
- R4: In external mode (`master_en`=1, `use_ext`=1), each low-to-high change of `ext_cyc_clk` raises `cycle_pulse` after the third rising edge following the change. Holding the input high, a falling change, and expiry of the internal counter produce no pulse.
- R5: With `master_en`=0, `cycle_pulse` stays 0 and `cycle_missed` stays 0, whatever `ext_cyc_clk` does. `cs_req` is cleared at the first edge that samples `master_en`=0.
- R6: `cs_req` rises in the same cycle as each `cycle_pulse`. It stays high until an edge samples `cs_ack`=1, and then reads 0 from that edge on. A new cycle start wins over a simultaneous acknowledge.
- R7: In external mode, `cycle_missed` goes high after the (MISS_CLKS+1)-th rising edge since entering the mode, or since the edge that acted on the last external rising change, provided no such change arrives in between. MISS_CLKS = PERIOD_CLKS + PERIOD_CLKS/2. The flag is cleared together with the pulse of the next external edge, and it is also cleared at the first edge after leaving external mode.
- R8: Any change of source restarts the period counter. After switching back to internal mode, the next pulse follows the R3 timing counted from the switch, whatever the counter held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz link clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Cycle master enable |
| use_ext | input | 1 | Source select: 1 = external 8 kHz clock, 0 = internal counter |
| ext_cyc_clk | input | 1 | External 8 kHz cycle clock, asynchronous |
| cs_ack | input | 1 | Transmitter acknowledge of the cycle start request |
| cycle_pulse | output | 1 | Single-clock cycle start pulse |
| cs_req | output | 1 | Cycle start packet request, held until acknowledged |
| cycle_missed | output | 1 | External cycle edge overdue |

## Verification
The assertions assume that `master_en`, `use_ext` and `cs_ack` are synchronous to `clk`. They also assume PERIOD_CLKS is at least 2, so that a counter wrap cannot come back in the very next cycle. Only `ext_cyc_clk` is treated as asynchronous, and it reaches the logic solely through the synchroniser.

The stimulus drives every input at the falling clock edge. It holds each level of the external clock for many cycles, so each rising change is seen exactly once. It overrides PERIOD_CLKS to 200 so that the missed-cycle window fits in a short run.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_INT      = 2'd1,
        ST_EXT_WAIT = 2'd2,
        ST_EXT_MISS = 2'd3
    } cyc_state_t;
endpackage

// File: rtl/cyc_sync.sv
module cyc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;

    // R4: a held-high input yields only one detected edge
    a_r4_single_edge: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/cyc_period_ctr.sv
module cyc_period_ctr #(
    parameter int PERIOD_CLKS = 6250,
    parameter int MISS_CLKS   = 9375,
    parameter int CW          = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic long_sel,
    output logic wrap_o
);
    localparam logic [CW-1:0] LAST_P = CW'(PERIOD_CLKS - 1);
    localparam logic [CW-1:0] LAST_M = CW'(MISS_CLKS - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last   = long_sel ? LAST_M : LAST_P;
    assign wrap_o = (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || clear)  cnt_q <= '0;
        else if (wrap_o)   cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    // R3: the count never passes the active limit
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);
endmodule

// File: rtl/cyc_fsm.sv
module cyc_fsm
    import cyc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic master_en,
    input  logic use_ext,
    input  logic rise,
    input  logic wrap,
    input  logic cs_ack,
    output logic clear,
    output logic long_sel,
    output logic cycle_pulse,
    output logic cs_req,
    output logic cycle_missed
);
    cyc_state_t state_q, state_nxt;
    logic       fire;
    logic       pulse_q, req_q;
    logic       in_ext;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        if (!master_en) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_nxt = use_ext ? ST_EXT_WAIT : ST_INT;
                ST_INT:      if (use_ext) state_nxt = ST_EXT_WAIT;
                ST_EXT_WAIT: begin
                    if (!use_ext)  state_nxt = ST_INT;
                    else if (rise) state_nxt = ST_EXT_WAIT;
                    else if (wrap) state_nxt = ST_EXT_MISS;
                end
                ST_EXT_MISS: begin
                    if (!use_ext)  state_nxt = ST_INT;
                    else if (rise) state_nxt = ST_EXT_WAIT;
                end
                default:     state_nxt = ST_IDLE;
            endcase
        end
    end

    assign in_ext   = (state_q == ST_EXT_WAIT) || (state_q == ST_EXT_MISS);
    assign long_sel = in_ext;
    assign clear    = (state_nxt != state_q) || (in_ext && rise);
    assign fire     = master_en &&
                      (((state_q == ST_INT) && !use_ext && wrap) ||
                       (in_ext && use_ext && rise));

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            pulse_q <= fire;
            if (!master_en)  req_q <= 1'b0;
            else if (fire)   req_q <= 1'b1;
            else if (cs_ack) req_q <= 1'b0;
        end
    end

    assign cycle_pulse  = pulse_q;
    assign cs_req       = req_q;
    assign cycle_missed = (state_q == ST_EXT_MISS);

    // R2: one clock wide
    a_r2_one_clock: assert property (@(posedge clk) disable iff (rst)
        cycle_pulse |=> !cycle_pulse);
    // R5: silent while cycle master is off
    a_r5_quiet_off: assert property (@(posedge clk) disable iff (rst)
        $past(!master_en) |-> (!cycle_pulse && !cycle_missed && !cs_req));
    // R6: request rises only alongside a cycle start
    a_r6_req_with_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_req) |-> cycle_pulse);
    // R7: missed flag only under external mode
    a_r7_missed_ext: assert property (@(posedge clk) disable iff (rst)
        cycle_missed |-> $past(master_en && use_ext));
endmodule

// File: rtl/cycle_tick_gen.sv
module cycle_tick_gen #(
    parameter int PERIOD_CLKS = 6250,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic master_en,
    input  logic use_ext,
    input  logic ext_cyc_clk,
    input  logic cs_ack,
    output logic cycle_pulse,
    output logic cs_req,
    output logic cycle_missed
);
    localparam int MISS_CLKS = PERIOD_CLKS + PERIOD_CLKS / 2;
    localparam int CW        = $clog2(MISS_CLKS);

    logic rise, wrap, clear, long_sel;

    cyc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_cyc_clk),
        .rise_o   (rise)
    );

    cyc_period_ctr #(
        .PERIOD_CLKS (PERIOD_CLKS),
        .MISS_CLKS   (MISS_CLKS),
        .CW          (CW)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .long_sel (long_sel),
        .wrap_o   (wrap)
    );

    cyc_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .master_en    (master_en),
        .use_ext      (use_ext),
        .rise         (rise),
        .wrap         (wrap),
        .cs_ack       (cs_ack),
        .clear        (clear),
        .long_sel     (long_sel),
        .cycle_pulse  (cycle_pulse),
        .cs_req       (cs_req),
        .cycle_missed (cycle_missed)
    );
endmodule

// File: tb/cycle_tick_gen_tb.sv
module cycle_tick_gen_tb_top;
    localparam int CLK_PERIOD = 20;
    localparam int P          = 200;
    localparam int MISS       = P + P / 2;
    localparam int WD_LIMIT   = 60000;

    logic clk = 1'b0;
    logic rst, master_en, use_ext, ext_cyc_clk, cs_ack;
    logic cycle_pulse, cs_req, cycle_missed;
    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cycle_tick_gen #(.PERIOD_CLKS(P)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .master_en    (master_en),
        .use_ext      (use_ext),
        .ext_cyc_clk  (ext_cyc_clk),
        .cs_ack       (cs_ack),
        .cycle_pulse  (cycle_pulse),
        .cs_req       (cs_req),
        .cycle_missed (cycle_missed)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cycles_to_pulse(input int maxc, output int k);
        k = 0;
        for (int i = 1; i <= maxc; i++) begin
            @(negedge clk);
            if (cycle_pulse) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic count_pulses(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cycle_pulse) cnt++;
        end
    endtask

    task automatic go_idle();
        master_en = 1'b0; use_ext = 1'b0; ext_cyc_clk = 1'b0; cs_ack = 1'b0;
        step(6);
    endtask

    task automatic t_reset();
        rst = 1'b1; master_en = 1'b0; use_ext = 1'b0; ext_cyc_clk = 1'b0; cs_ack = 1'b0;
        step(3);
        check("R1 pulse in reset", int'(cycle_pulse), 0);
        check("R1 req in reset", int'(cs_req), 0);
        check("R1 missed in reset", int'(cycle_missed), 0);
        rst = 1'b0;
        step(1);
        check("R1 outputs after reset", int'({cycle_pulse, cs_req, cycle_missed}), 0);
    endtask

    task automatic t_internal();
        int k;
        go_idle();
        master_en = 1'b1;
        cycles_to_pulse(3 * P, k);
        check("R3 first internal pulse", k, P + 1);
        check("R6 req with pulse", int'(cs_req), 1);
        step(1);
        check("R2 pulse width", int'(cycle_pulse), 0);
        cycles_to_pulse(3 * P, k);
        check("R3 period", k + 1, P);
        cycles_to_pulse(3 * P, k);
        check("R3 period again", k, P);
    endtask

    task automatic t_ack();
        int k;
        go_idle();
        master_en = 1'b1;
        cycles_to_pulse(3 * P, k);
        step(5);
        check("R6 req held", int'(cs_req), 1);
        cs_ack = 1'b1;
        step(1);
        cs_ack = 1'b0;
        check("R6 req cleared by ack", int'(cs_req), 0);
        cycles_to_pulse(3 * P, k);
        check("R6 req on next pulse", int'(cs_req), 1);
        master_en = 1'b0;
        step(1);
        check("R5 req cleared on disable", int'(cs_req), 0);
    endtask

    task automatic t_disabled();
        int cnt, c2;
        go_idle();
        count_pulses(P + 20, cnt);
        ext_cyc_clk = 1'b1;
        count_pulses(30, c2);
        ext_cyc_clk = 1'b0;
        step(30);
        use_ext = 1'b1;
        ext_cyc_clk = 1'b1;
        count_pulses(MISS + 20, cnt);
        cnt += c2;
        check("R5 no pulse when disabled", cnt, 0);
        check("R5 no missed when disabled", int'(cycle_missed), 0);
        check("R5 no req when disabled", int'(cs_req), 0);
    endtask

    task automatic t_external();
        int k, cnt;
        go_idle();
        master_en = 1'b1; use_ext = 1'b1;
        step(5);
        ext_cyc_clk = 1'b1;
        cycles_to_pulse(20, k);
        check("R4 edge to pulse latency", k, 3);
        count_pulses(60, cnt);
        check("R4 held high no pulse", cnt, 0);
        ext_cyc_clk = 1'b0;
        count_pulses(60, cnt);
        check("R4 falling no pulse", cnt, 0);
        ext_cyc_clk = 1'b1;
        cycles_to_pulse(20, k);
        check("R4 second edge latency", k, 3);
        ext_cyc_clk = 1'b0;
        count_pulses(P + 10, cnt);
        check("R4 internal wrap ignored in ext mode", cnt, 0);
    endtask

    task automatic t_missed();
        int k;
        go_idle();
        master_en = 1'b1; use_ext = 1'b1;
        step(MISS);
        check("R7 not yet missed", int'(cycle_missed), 0);
        step(1);
        check("R7 missed set", int'(cycle_missed), 1);
        ext_cyc_clk = 1'b1;
        cycles_to_pulse(20, k);
        check("R7 recovery pulse latency", k, 3);
        check("R7 missed cleared by edge", int'(cycle_missed), 0);
        step(MISS + 2);
        check("R7 missed again", int'(cycle_missed), 1);
        use_ext = 1'b0;
        step(1);
        check("R7 missed cleared leaving ext", int'(cycle_missed), 0);
    endtask

    task automatic t_switch();
        int k, cnt;
        go_idle();
        master_en = 1'b1;
        cycles_to_pulse(3 * P, k);
        step(50);
        use_ext = 1'b1;
        count_pulses(20, cnt);
        check("R8 no pulse after switch to ext", cnt, 0);
        use_ext = 1'b0;
        cycles_to_pulse(3 * P, k);
        check("R8 counter restarted on switch", k, P + 1);
    endtask

    initial begin
        rst = 1'b1; master_en = 1'b0; use_ext = 1'b0; ext_cyc_clk = 1'b0; cs_ack = 1'b0;
        @(negedge clk);
        t_reset();
        t_internal();
        t_ack();
        t_disabled();
        t_external();
        t_missed();
        t_switch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule